// File: doc/BRIEF.md
# Multi-Channel DMA Channel Controller

This block keeps a bank of per-channel DMA control words and answers transfer requests from the devices attached to the lower channels. Software programs each channel through a 32-bit register port: a mode word, a control/status word, a remaining byte count and a transfer address. A device asks for a transfer by giving a channel number, a length and a direction. The block first checks that the request matches the channel's programming. If it does, it starts one memory transfer through a start/done handshake, using the channel address and a length clamped to the remaining count. When the handshake completes, it updates the channel's status and count.

If a request meets a channel that is switched off, or one programmed for the opposite direction, no transfer starts. The channel instead records a memory-error flag, and a sticky fault bit for that channel is set in a fault-source register that software reads. Address translation and the data movement itself sit outside this block. The transfer address is handed out as stored and is never advanced.

Top module: `dmac_chan_ctrl`

## Requirements
- R1: After reset every word of every channel reads 0, the fault-source register reads 0, and `busy`, `mem_start`, `rsp_done` and `rsp_err` are low.
- R2: Word w (0 mode, 1 control/status, 2 count, 3 address) of channel n sits at offset 0x100 + 0x20·n + 8·w, for all 8 channels. It is fully readable and writable as 32 bits. Address bits above bit 13 and bits 1:0 are ignored.
- R3: An offset inside 0x100–0x1FF with bit 2 set, or any other unmapped offset, reads 0, and a write to it changes no register.
- R4: The fault-source register at offset 0x200 has bit n set once a request on channel n has faulted. Bits stay set until reset, and writes to the offset have no effect.
- R5: When a request is accepted, bits 8 (terminal count), 9 (memory error) and 10 (address error) of that channel's control word are cleared. All other bits are kept.
- R6: A request is refused when control bit 0 (enable) is 0, or when the request direction (`req_to_dev`, 1 = memory to device) differs from control bit 1. On a refusal, bit 9 is set, fault bit n is set, `rsp_err` pulses for one cycle right after the accepting edge, no `mem_start` is issued, and the count does not change.
- R7: A consistent request makes `mem_start` pulse for exactly one cycle right after the accepting edge. During that pulse, `mem_addr` equals the address word, `mem_len` equals the smaller of the request length and the count word, and `mem_to_dev` equals the request direction.
- R8: On the edge where `mem_done` is seen, control bit 8 is set and the transferred length is subtracted from the count. `rsp_done` then pulses for one cycle with `rsp_len` equal to that length. The address word does not change.
- R9: `busy` is high from the cycle after acceptance until the edge that takes `mem_done`. Any `req_valid` seen while busy is ignored.
- R10: A request on a channel whose count is 0 still issues `mem_start` with `mem_len` 0. On completion the count stays 0 and bit 8 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (16) | Register byte offset |
| reg_wdata | input | REG_W (32) | Register write data |
| reg_rdata | output | REG_W (32) | Register read data, same cycle as `reg_rd` |
| req_valid | input | 1 | Device transfer request |
| req_chan | input | log2(NUM_DEV) (2) | Requesting channel |
| req_len | input | REG_W (32) | Requested byte length |
| req_to_dev | input | 1 | Direction: 1 memory to device, 0 device to memory |
| busy | output | 1 | A transfer is outstanding |
| rsp_done | output | 1 | One-cycle transfer-complete pulse |
| rsp_err | output | 1 | One-cycle refused-request pulse |
| rsp_len | output | REG_W (32) | Transferred length, valid with `rsp_done` |
| mem_start | output | 1 | One-cycle memory transfer start |
| mem_addr | output | REG_W (32) | Transfer address |
| mem_len | output | REG_W (32) | Clamped transfer length |
| mem_to_dev | output | 1 | Transfer direction |
| mem_done | input | 1 | Memory transfer finished |

## Verification
Register reads are combinational, so the bench samples `reg_rdata` 1 ns after presenting the read in the low half of the clock. A register write is visible from the falling edge after its rising edge. A request presented before edge k produces `rsp_err` or `mem_start` in the cycle after edge k, and the updated control word and fault bits are readable in that same cycle. `rsp_done` and the new count appear in the cycle after the edge that takes `mem_done`. Every task drives inputs on a falling edge and checks each result at the first falling edge after the edge that must produce it, including a check one cycle later that each pulse has dropped.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
    localparam int OFS_W        = 14;
    localparam int WORDS_PER_CH = 4;

    localparam logic [OFS_W-1:0] CHAN_BASE = 14'h0100;
    localparam logic [OFS_W-1:0] FAULT_OFS = 14'h0200;

    // control/status word bit positions
    localparam int EN_BIT    = 0;
    localparam int TODEV_BIT = 1;
    localparam int TC_BIT    = 8;
    localparam int MERR_BIT  = 9;
    localparam int AERR_BIT  = 10;

    typedef enum logic [1:0] {
        WRD_MODE  = 2'd0,
        WRD_CTRL  = 2'd1,
        WRD_COUNT = 2'd2,
        WRD_ADDR  = 2'd3
    } chan_word_e;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_WAIT = 1'b1
    } eng_state_e;
endpackage

// File: rtl/dmac_addr_dec.sv
`timescale 1ns/1ps
module dmac_addr_dec
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NUM_CH = 8,
    localparam int CH_IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_chan,
    output logic              hit_fault,
    output logic [CH_IW-1:0]  chan,
    output logic [1:0]        word
);
    logic [OFS_W-1:0] ofs;
    logic             in_win;
    logic             ch_ok;
    logic             unused_addr_bits;

    assign ofs = addr[OFS_W-1:0];

    generate
        if (ADDR_W > OFS_W) begin : g_hi
            assign unused_addr_bits = ^{addr[ADDR_W-1:OFS_W], ofs[1:0]};
        end else begin : g_nohi
            assign unused_addr_bits = ^ofs[1:0];
        end
        if (NUM_CH == 8) begin : g_full
            assign ch_ok = 1'b1;
        end else begin : g_part
            assign ch_ok = (ofs[7:5] < 3'(NUM_CH));
        end
    endgenerate

    // channel window, 8-byte word spacing: bit 2 set is a hole
    assign in_win    = (ofs[OFS_W-1:8] == CHAN_BASE[OFS_W-1:8]) && !ofs[2];
    assign hit_chan  = in_win && ch_ok;
    assign hit_fault = (ofs[OFS_W-1:2] == FAULT_OFS[OFS_W-1:2]);
    assign chan      = ofs[5 +: CH_IW];
    assign word      = ofs[4:3];
endmodule

// File: rtl/dmac_chan_regs.sv
`timescale 1ns/1ps
module dmac_chan_regs
    import dmac_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int REG_W  = 32,
    localparam int CH_IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [CH_IW-1:0] bus_chan,
    input  logic [1:0]       bus_word,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic [CH_IW-1:0] rd_chan,
    input  logic [1:0]       rd_word,
    output logic [REG_W-1:0] rd_data,
    input  logic [CH_IW-1:0] eng_chan,
    input  logic             eng_st_we,
    input  logic [REG_W-1:0] eng_st_wdata,
    input  logic             eng_cnt_we,
    input  logic [REG_W-1:0] eng_cnt_wdata,
    output logic [REG_W-1:0] eng_ctrl,
    output logic [REG_W-1:0] eng_count,
    output logic [REG_W-1:0] eng_addr
);
    logic [REG_W-1:0] regs_q [NUM_CH][WORDS_PER_CH];
    logic [REG_W-1:0] regs_d [NUM_CH][WORDS_PER_CH];

    always_comb begin
        regs_d = regs_q;
        if (bus_we) begin
            regs_d[bus_chan][bus_word] = bus_wdata;
        end
        // engine updates win over a same-cycle software write
        if (eng_st_we) begin
            regs_d[eng_chan][WRD_CTRL] = eng_st_wdata;
        end
        if (eng_cnt_we) begin
            regs_d[eng_chan][WRD_COUNT] = eng_cnt_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                for (int w = 0; w < WORDS_PER_CH; w++) begin
                    regs_q[c][w] <= '0;
                end
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_data   = regs_q[rd_chan][rd_word];
    assign eng_ctrl  = regs_q[eng_chan][WRD_CTRL];
    assign eng_count = regs_q[eng_chan][WRD_COUNT];
    assign eng_addr  = regs_q[eng_chan][WRD_ADDR];

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_hold
            // R8
            addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(bus_we && bus_chan == CH_IW'(c) && bus_word == WRD_ADDR)
                |=> $stable(regs_q[c][WRD_ADDR]));
        end
    endgenerate
endmodule

// File: rtl/dmac_xfer_engine.sv
`timescale 1ns/1ps
module dmac_xfer_engine
    import dmac_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int NUM_DEV = 4,
    parameter int REG_W   = 32,
    localparam int CH_IW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int DEV_IW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DEV_IW-1:0] req_chan,
    input  logic [REG_W-1:0]  req_len,
    input  logic              req_to_dev,
    input  logic [REG_W-1:0]  ctrl,
    input  logic [REG_W-1:0]  count,
    input  logic [REG_W-1:0]  addr,
    output logic [CH_IW-1:0]  eng_chan,
    output logic              st_we,
    output logic [REG_W-1:0]  st_wdata,
    output logic              cnt_we,
    output logic [REG_W-1:0]  cnt_wdata,
    output logic              mem_start,
    output logic [REG_W-1:0]  mem_addr,
    output logic [REG_W-1:0]  mem_len,
    output logic              mem_to_dev,
    input  logic              mem_done,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [REG_W-1:0]  rsp_len,
    output logic              busy,
    output logic [REG_W-1:0]  fault_src
);
    localparam logic [REG_W-1:0] FLAG_MASK = (REG_W'(1) << TC_BIT)
                                           | (REG_W'(1) << MERR_BIT)
                                           | (REG_W'(1) << AERR_BIT);

    typedef struct packed {
        eng_state_e         state;
        logic [CH_IW-1:0]   chan;
        logic [REG_W-1:0]   len;
        logic [REG_W-1:0]   addr;
        logic               to_dev;
        logic               mem_start;
        logic               rsp_done;
        logic               rsp_err;
        logic [NUM_CH-1:0]  fault;
    } eng_regs_t;

    eng_regs_t        eng_q, eng_d;
    logic [CH_IW-1:0] req_ch;
    logic [REG_W-1:0] ctrl_clr;
    logic [REG_W-1:0] clamp_len;
    logic             chan_ok;

    assign req_ch   = CH_IW'(req_chan);
    assign eng_chan = (eng_q.state == ENG_IDLE) ? req_ch : eng_q.chan;

    always_comb begin
        eng_d           = eng_q;
        eng_d.mem_start = 1'b0;
        eng_d.rsp_done  = 1'b0;
        eng_d.rsp_err   = 1'b0;
        st_we           = 1'b0;
        st_wdata        = ctrl;
        cnt_we          = 1'b0;
        cnt_wdata       = count;
        ctrl_clr        = ctrl & ~FLAG_MASK;
        chan_ok         = ctrl[EN_BIT] && (ctrl[TODEV_BIT] == req_to_dev);
        clamp_len       = (req_len < count) ? req_len : count;

        case (eng_q.state)
            ENG_IDLE: begin
                if (req_valid) begin
                    st_we        = 1'b1;
                    eng_d.chan   = req_ch;
                    eng_d.to_dev = req_to_dev;
                    if (chan_ok) begin
                        st_wdata        = ctrl_clr;
                        eng_d.len       = clamp_len;
                        eng_d.addr      = addr;
                        eng_d.mem_start = 1'b1;
                        eng_d.state     = ENG_WAIT;
                    end else begin
                        st_wdata            = ctrl_clr | (REG_W'(1) << MERR_BIT);
                        eng_d.fault[req_ch] = 1'b1;
                        eng_d.len           = '0;
                        eng_d.rsp_err       = 1'b1;
                    end
                end
            end
            ENG_WAIT: begin
                if (mem_done) begin
                    st_we          = 1'b1;
                    st_wdata       = ctrl | (REG_W'(1) << TC_BIT);
                    cnt_we         = 1'b1;
                    cnt_wdata      = count - eng_q.len;
                    eng_d.rsp_done = 1'b1;
                    eng_d.state    = ENG_IDLE;
                end
            end
            default: eng_d.state = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q <= '{state: ENG_IDLE, default: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign mem_start  = eng_q.mem_start;
    assign mem_addr   = eng_q.addr;
    assign mem_len    = eng_q.len;
    assign mem_to_dev = eng_q.to_dev;
    assign rsp_done   = eng_q.rsp_done;
    assign rsp_err    = eng_q.rsp_err;
    assign rsp_len    = eng_q.len;
    assign busy       = (eng_q.state == ENG_WAIT);
    assign fault_src  = REG_W'(eng_q.fault);

    // R7
    len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_start |-> (mem_len <= $past(count)) && (mem_len <= $past(req_len)));
    // R7
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_start |=> !mem_start);
    // R6
    err_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> eng_q.fault[eng_q.chan] && !mem_start && !busy);
    // R4
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eng_q.fault) & ~eng_q.fault) == '0);
    // R8
    done_after_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(mem_done) && $past(busy));
    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mem_done |=> busy);
endmodule

// File: rtl/dmac_chan_ctrl.sv
`timescale 1ns/1ps
module dmac_chan_ctrl
    import dmac_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int REG_W   = 32,
    parameter int NUM_CH  = 8,
    parameter int NUM_DEV = 4,
    localparam int CH_IW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int DEV_IW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              req_valid,
    input  logic [DEV_IW-1:0] req_chan,
    input  logic [REG_W-1:0]  req_len,
    input  logic              req_to_dev,
    output logic              busy,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [REG_W-1:0]  rsp_len,
    output logic              mem_start,
    output logic [REG_W-1:0]  mem_addr,
    output logic [REG_W-1:0]  mem_len,
    output logic              mem_to_dev,
    input  logic              mem_done
);
    logic             hit_chan, hit_fault;
    logic [CH_IW-1:0] dec_chan;
    logic [1:0]       dec_word;
    logic [REG_W-1:0] chan_rdata, fault_src;
    logic [CH_IW-1:0] eng_chan;
    logic             st_we, cnt_we;
    logic [REG_W-1:0] st_wdata, cnt_wdata;
    logic [REG_W-1:0] eng_ctrl, eng_count, eng_addr;

    dmac_addr_dec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) dec_i (
        .addr      (reg_addr),
        .hit_chan  (hit_chan),
        .hit_fault (hit_fault),
        .chan      (dec_chan),
        .word      (dec_word)
    );

    dmac_chan_regs #(.NUM_CH(NUM_CH), .REG_W(REG_W)) regs_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_we        (reg_wr && hit_chan),
        .bus_chan      (dec_chan),
        .bus_word      (dec_word),
        .bus_wdata     (reg_wdata),
        .rd_chan       (dec_chan),
        .rd_word       (dec_word),
        .rd_data       (chan_rdata),
        .eng_chan      (eng_chan),
        .eng_st_we     (st_we),
        .eng_st_wdata  (st_wdata),
        .eng_cnt_we    (cnt_we),
        .eng_cnt_wdata (cnt_wdata),
        .eng_ctrl      (eng_ctrl),
        .eng_count     (eng_count),
        .eng_addr      (eng_addr)
    );

    dmac_xfer_engine #(.NUM_CH(NUM_CH), .NUM_DEV(NUM_DEV), .REG_W(REG_W)) eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_chan   (req_chan),
        .req_len    (req_len),
        .req_to_dev (req_to_dev),
        .ctrl       (eng_ctrl),
        .count      (eng_count),
        .addr       (eng_addr),
        .eng_chan   (eng_chan),
        .st_we      (st_we),
        .st_wdata   (st_wdata),
        .cnt_we     (cnt_we),
        .cnt_wdata  (cnt_wdata),
        .mem_start  (mem_start),
        .mem_addr   (mem_addr),
        .mem_len    (mem_len),
        .mem_to_dev (mem_to_dev),
        .mem_done   (mem_done),
        .rsp_done   (rsp_done),
        .rsp_err    (rsp_err),
        .rsp_len    (rsp_len),
        .busy       (busy),
        .fault_src  (fault_src)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (hit_chan) begin
                reg_rdata = chan_rdata;
            end else if (hit_fault) begin
                reg_rdata = fault_src;
            end
        end
    end

    // R6
    no_start_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !mem_start && !rsp_done);
endmodule

// File: tb/dmac_chan_ctrl_tb.sv
`timescale 1ns/1ps
module dmac_chan_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [1:0]  req_chan = '0;
    logic [31:0] req_len = '0;
    logic        req_to_dev = 1'b0;
    logic        busy, rsp_done, rsp_err, mem_start, mem_to_dev;
    logic [31:0] rsp_len, mem_addr, mem_len;
    logic        mem_done = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk; // 200 MHz

    dmac_chan_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_chan(req_chan), .req_len(req_len),
        .req_to_dev(req_to_dev), .busy(busy), .rsp_done(rsp_done),
        .rsp_err(rsp_err), .rsp_len(rsp_len), .mem_start(mem_start),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_to_dev(mem_to_dev),
        .mem_done(mem_done)
    );

    function automatic logic [15:0] ofs(input int ch, input int w);
        return 16'(16'h100 + ch * 32 + w * 8);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        chk(req, $sformatf("read @%h", a), reg_rdata, exp);
        reg_rd = 1'b0;
    endtask

    // returns at the falling edge right after the accepting edge
    task automatic send_req(input int ch, input logic [31:0] len, input logic dir);
        @(negedge clk);
        req_valid = 1'b1; req_chan = 2'(ch); req_len = len; req_to_dev = dir;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // called at a falling edge; returns at the falling edge after mem_done is taken
    task automatic finish_xfer();
        mem_done = 1'b1;
        @(negedge clk);
        mem_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "mem_start", 32'(mem_start), 0);
        chk("R1", "rsp_done", 32'(rsp_done), 0);
        chk("R1", "rsp_err", 32'(rsp_err), 0);
        for (int c = 0; c < 8; c++)
            for (int w = 0; w < 4; w++) rd_chk("R1", ofs(c, w), 32'h0);
        rd_chk("R1", 16'h0200, 32'h0);
    endtask

    task automatic t_map();
        for (int c = 0; c < 8; c++)
            for (int w = 0; w < 4; w++) wr(ofs(c, w), 32'hA500_0000 | (c << 8) | w);
        for (int c = 0; c < 8; c++)
            for (int w = 0; w < 4; w++) rd_chk("R2", ofs(c, w), 32'hA500_0000 | (c << 8) | w);
        for (int c = 0; c < 8; c += 3)
            rd_chk("R2", ofs(c, 2) | 16'hC003, 32'hA500_0002 | (c << 8));
        wr(ofs(5, 2) | 16'h4002, 32'h1111_2222);
        rd_chk("R2", ofs(5, 2), 32'h1111_2222);
    endtask

    task automatic t_unmapped();
        wr(16'h0104, 32'hFFFF_FFFF);
        wr(16'h0008, 32'hFFFF_FFFF);
        rd_chk("R3", ofs(0, 0), 32'hA500_0000);
        rd_chk("R3", ofs(0, 1), 32'hA500_0001);
        rd_chk("R3", 16'h0104, 32'h0);
        rd_chk("R3", 16'h0008, 32'h0);
        rd_chk("R3", 16'h0204, 32'h0);
    endtask

    task automatic t_good();
        wr(ofs(0, 1), 32'h0000_0701);
        wr(ofs(0, 2), 32'h0000_0100);
        wr(ofs(0, 3), 32'h8000_1000);
        send_req(0, 32'h40, 1'b0);
        chk("R7", "mem_start", 32'(mem_start), 1);
        chk("R7", "mem_addr", mem_addr, 32'h8000_1000);
        chk("R7", "mem_len", mem_len, 32'h40);
        chk("R7", "mem_to_dev", 32'(mem_to_dev), 0);
        chk("R9", "busy", 32'(busy), 1);
        #1; reg_rd = 1'b1; reg_addr = ofs(0, 1); #1;
        chk("R5", "flags cleared", reg_rdata, 32'h0000_0001);
        reg_rd = 1'b0;
        @(negedge clk);
        chk("R7", "start pulse dropped", 32'(mem_start), 0);
        chk("R9", "still busy", 32'(busy), 1);
        finish_xfer();
        chk("R8", "rsp_done", 32'(rsp_done), 1);
        chk("R8", "rsp_len", rsp_len, 32'h40);
        chk("R9", "busy released", 32'(busy), 0);
        @(negedge clk);
        chk("R8", "done pulse dropped", 32'(rsp_done), 0);
        rd_chk("R8", ofs(0, 1), 32'h0000_0101);
        rd_chk("R8", ofs(0, 2), 32'h0000_00C0);
        rd_chk("R8", ofs(0, 3), 32'h8000_1000);
    endtask

    task automatic t_clamp();
        wr(ofs(1, 1), 32'h0000_0003);
        wr(ofs(1, 2), 32'h0000_0020);
        wr(ofs(1, 3), 32'h1234_0000);
        send_req(1, 32'h80, 1'b1);
        chk("R7", "clamped mem_len", mem_len, 32'h20);
        chk("R7", "mem_to_dev", 32'(mem_to_dev), 1);
        @(negedge clk);
        finish_xfer();
        chk("R8", "rsp_len clamp", rsp_len, 32'h20);
        rd_chk("R8", ofs(1, 2), 32'h0);
        rd_chk("R8", ofs(1, 1), 32'h0000_0103);
    endtask

    task automatic t_zero();
        send_req(1, 32'h10, 1'b1);
        chk("R10", "mem_start", 32'(mem_start), 1);
        chk("R10", "mem_len", mem_len, 32'h0);
        @(negedge clk);
        finish_xfer();
        chk("R10", "rsp_done", 32'(rsp_done), 1);
        rd_chk("R10", ofs(1, 2), 32'h0);
        rd_chk("R10", ofs(1, 1), 32'h0000_0103);
    endtask

    task automatic t_disabled();
        wr(ofs(2, 1), 32'h0000_0710);
        wr(ofs(2, 2), 32'h0000_0050);
        send_req(2, 32'h8, 1'b0);
        chk("R6", "rsp_err", 32'(rsp_err), 1);
        chk("R6", "no mem_start", 32'(mem_start), 0);
        chk("R6", "not busy", 32'(busy), 0);
        @(negedge clk);
        chk("R6", "err pulse dropped", 32'(rsp_err), 0);
        rd_chk("R6", ofs(2, 1), 32'h0000_0210);
        rd_chk("R6", ofs(2, 2), 32'h0000_0050);
        rd_chk("R4", 16'h0200, 32'h4);
    endtask

    task automatic t_dir();
        send_req(0, 32'h8, 1'b1);
        chk("R6", "dir rsp_err", 32'(rsp_err), 1);
        chk("R6", "dir no start", 32'(mem_start), 0);
        rd_chk("R6", ofs(0, 1), 32'h0000_0201);
        rd_chk("R6", ofs(0, 2), 32'h0000_00C0);
        rd_chk("R4", 16'h0200, 32'h5);
    endtask

    task automatic t_busy();
        wr(ofs(3, 1), 32'h0);
        send_req(0, 32'h10, 1'b0);
        chk("R9", "accepted", 32'(mem_start), 1);
        req_valid = 1'b1; req_chan = 2'd3; req_len = 32'h4; req_to_dev = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R9", "busy during ignored req", 32'(busy), 1);
            chk("R9", "no rsp_err while busy", 32'(rsp_err), 0);
        end
        req_valid = 1'b0;
        rd_chk("R9", 16'h0200, 32'h5);
        rd_chk("R9", ofs(3, 1), 32'h0);
        @(negedge clk);
        finish_xfer();
        chk("R9", "rsp_done", 32'(rsp_done), 1);
        rd_chk("R8", ofs(0, 2), 32'h0000_00B0);
        rd_chk("R8", ofs(0, 1), 32'h0000_0101);
        send_req(3, 32'h4, 1'b0);
        chk("R6", "ch3 refused", 32'(rsp_err), 1);
        rd_chk("R4", 16'h0200, 32'hD);
    endtask

    task automatic t_fault_ro();
        wr(16'h0200, 32'h0);
        rd_chk("R4", 16'h0200, 32'hD);
        wr(16'h0200, 32'hFFFF_FFFF);
        rd_chk("R4", 16'h0200, 32'hD);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_unmapped();
        t_good();
        t_clamp();
        t_zero();
        t_disabled();
        t_dir();
        t_busy();
        t_fault_ro();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog actual=hung expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule